// File: doc/BRIEF.md
# Dual-Channel DMA Control and Status Register Bank

This block is the control and status register bank that sits in front of a two-channel DMA engine. Software reaches it through a plain 32-bit register port with separate write and read strobes. For each channel it holds a transfer length, a source address, a destination address, a next-descriptor pointer, a control word, a priority word, an interrupt enable and a completion flag. It also makes the engine's current-descriptor pointer readable. The same register of both channels sits in one 16-byte group, and the channels are one word apart inside that group.

The decoded control fields go straight to each channel engine as wires. A write that sets the fetch bit becomes a single-cycle pulse to that engine. The engine reports its busy state, its current descriptor and a completion pulse. Completion pulses latch into per-channel flags. The enabled flags of both channels are merged onto one shared interrupt line.

The register port has no back-pressure. A write takes effect at the clock edge where it is sampled. Read data appears, qualified by a valid strobe, exactly one cycle after the read strobe. There is no stall and no ready signal, so the requester must accept the data in that cycle.

Top module: `tdma_regbank`

## Requirements
- R1: Byte offset bits [7:4] select the register group and bits [3:2] select the channel; bits [1:0] are ignored. The groups are: 0x0 length, 0x1 source, 0x2 destination, 0x3 next descriptor, 0x4 control, 0x6 priority, 0x7 current descriptor, 0x8 interrupt enable, 0xA completion flag. Channel 0's length is therefore at 0x00 and channel 1's at 0x04.
- R2: While reset is low, every stored register is cleared, and `irq`, `bus_rvalid`, `bus_rdata` and every `ch_fetch` bit are 0.
- R3: `bus_rvalid` is high in the cycle after each cycle in which `bus_ren` is high, and `bus_rdata` holds the addressed register in that cycle. An offset with an unlisted group, a channel field of 2 or more, or a nonzero bit above bit 7 reads as 0, and writes to it change nothing.
- R4: The control word stores bits 24:22, 21, 20, 17, 16, 12, 10, 9, 8:6, 5:4 and 3:2 as written. All other control bits read back as 0, apart from bit 14 (see R5).
- R5: Control bit 14 reads as the channel's `ch_busy` input, and writes to it have no effect.
- R6: Writing control with bit 13 set raises that channel's `ch_fetch` for exactly the one cycle after the write edge. Bit 13 always reads back as 0.
- R7: The exported control fields follow the stored word: `ch_enable` is bit 12, `ch_abort` bit 20, `ch_chain` bit 9, `ch_burst` bits 8:6, `ch_dst_dir` bits 5:4, `ch_src_dir` bits 3:2 and `ch_sample` bits 24:22. A direction code of 0 means increment and 2 means hold.
- R8: A `ch_done` pulse sets that channel's completion flag (bit 0 of group 0xA) whatever the interrupt enable holds.
- R9: A write to the completion flag with bit 0 equal to 0 clears it. A write with bit 0 equal to 1 leaves it unchanged. A completion pulse in the same cycle as a clearing write wins, and the flag stays set. All other bits of the flag register read 0.
- R10: Interrupt enable bit 0 is stored and the other bits read 0. `irq` is high exactly while at least one channel has both its flag and its enable set, and both channels share this one line.
- R11: The current-descriptor group reads the channel's `ch_cur_desc` input, and writes to it have no effect.
- R12: The length, source, destination, next-descriptor and priority registers store all 32 written bits. The first four are driven on `ch_byte_cnt`, `ch_src_addr`, `ch_dst_addr` and `ch_next_desc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data qualifier, one cycle after bus_ren |
| ch_busy | input | NCH | Engine busy per channel |
| ch_cur_desc | input | NCH x 32 | Engine current-descriptor pointer per channel |
| ch_done | input | NCH | Completion pulse per channel |
| ch_byte_cnt | output | NCH x 32 | Transfer length per channel |
| ch_src_addr | output | NCH x 32 | Source address per channel |
| ch_dst_addr | output | NCH x 32 | Destination address per channel |
| ch_next_desc | output | NCH x 32 | Next-descriptor pointer per channel |
| ch_enable | output | NCH | Channel run enable |
| ch_abort | output | NCH | Channel abort request |
| ch_chain | output | NCH | Descriptor chaining mode |
| ch_fetch | output | NCH | One-cycle fetch-next-descriptor pulse |
| ch_burst | output | NCH x 3 | Burst size code |
| ch_src_dir | output | NCH x 2 | Source address direction code |
| ch_dst_dir | output | NCH x 2 | Destination address direction code |
| ch_sample | output | NCH x 3 | Sample size code |
| irq | output | 1 | Shared completion interrupt |

## Verification
The embedded properties assume that reset is held low across at least one rising edge. They also assume that `ch_done`, `ch_busy` and `ch_cur_desc` are synchronous to `clk`. Given that, the fetch pulse and any fall of `irq` can always be traced back to a register write in the cycle before. The stimulus changes every input only on falling clock edges and never issues a read and a write in the same cycle. It keeps `ch_busy` and `ch_cur_desc` steady across each read that observes them. It raises `ch_done` for single cycles only, once deliberately in the same cycle as a clearing write.

// File: rtl/tdma_regs_pkg.sv
package tdma_regs_pkg;

  typedef enum logic [3:0] {
    SEL_CNT, SEL_SRC, SEL_DST, SEL_NXT, SEL_CTRL,
    SEL_PRIO, SEL_CUR, SEL_MASK, SEL_STAT, SEL_NONE
  } reg_sel_e;

  // register group codes (offset bits [7:4])
  localparam logic [3:0] GRP_CNT  = 4'h0;
  localparam logic [3:0] GRP_SRC  = 4'h1;
  localparam logic [3:0] GRP_DST  = 4'h2;
  localparam logic [3:0] GRP_NXT  = 4'h3;
  localparam logic [3:0] GRP_CTRL = 4'h4;
  localparam logic [3:0] GRP_PRIO = 4'h6;
  localparam logic [3:0] GRP_CUR  = 4'h7;
  localparam logic [3:0] GRP_MASK = 4'h8;
  localparam logic [3:0] GRP_STAT = 4'hA;

  // control word bit positions
  localparam int CB_SAMPLE = 22;  // 3 bits
  localparam int CB_SERIAL = 21;
  localparam int CB_ABORT  = 20;
  localparam int CB_CLOSE  = 17;
  localparam int CB_PACK   = 16;
  localparam int CB_ACTIVE = 14;
  localparam int CB_FETCH  = 13;
  localparam int CB_ENABLE = 12;
  localparam int CB_IMODE  = 10;
  localparam int CB_CHAIN  = 9;
  localparam int CB_BURST  = 6;   // 3 bits
  localparam int CB_DDIR   = 4;   // 2 bits
  localparam int CB_SDIR   = 2;   // 2 bits

  localparam logic [31:0] CTRL_WMASK =
      (32'h7 << CB_SAMPLE) | (32'h1 << CB_SERIAL) | (32'h1 << CB_ABORT) |
      (32'h1 << CB_CLOSE)  | (32'h1 << CB_PACK)   | (32'h1 << CB_ENABLE) |
      (32'h1 << CB_IMODE)  | (32'h1 << CB_CHAIN)  | (32'h7 << CB_BURST) |
      (32'h3 << CB_DDIR)   | (32'h3 << CB_SDIR);

endpackage

// File: rtl/tdma_addr_dec.sv
module tdma_addr_dec
  import tdma_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NCH    = 2,
  parameter int CH_W   = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [CH_W-1:0]   chan,
  output logic              hit
);
  logic upper_zero;
  logic unused_lsb;
  logic [3:0] grp;

  assign unused_lsb = ^addr[1:0];
  assign grp  = addr[7:4];
  assign chan = addr[3:2];

  generate
    if (ADDR_W > 8) begin : g_hi
      assign upper_zero = ~|addr[ADDR_W-1:8];
    end else begin : g_lo
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    case (grp)
      GRP_CNT:  sel = SEL_CNT;
      GRP_SRC:  sel = SEL_SRC;
      GRP_DST:  sel = SEL_DST;
      GRP_NXT:  sel = SEL_NXT;
      GRP_CTRL: sel = SEL_CTRL;
      GRP_PRIO: sel = SEL_PRIO;
      GRP_CUR:  sel = SEL_CUR;
      GRP_MASK: sel = SEL_MASK;
      GRP_STAT: sel = SEL_STAT;
      default:  sel = SEL_NONE;
    endcase
  end

  assign hit = upper_zero && (int'(chan) < NCH) && (sel != SEL_NONE);
endmodule

// File: rtl/tdma_chan_regs.sv
module tdma_chan_regs
  import tdma_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  reg_sel_e    sel,
  input  logic [31:0] wdata,
  input  logic        busy_i,
  input  logic [31:0] cur_desc_i,
  input  logic        done_i,
  output logic [31:0] rd_data_o,
  output logic [31:0] cnt_o,
  output logic [31:0] src_o,
  output logic [31:0] dst_o,
  output logic [31:0] nxt_o,
  output logic        enable_o,
  output logic        abort_o,
  output logic        chain_o,
  output logic        fetch_o,
  output logic [2:0]  burst_o,
  output logic [1:0]  sdir_o,
  output logic [1:0]  ddir_o,
  output logic [2:0]  sample_o,
  output logic        stat_o,
  output logic        mask_o
);
  logic [31:0] cnt_q, src_q, dst_q, nxt_q, ctrl_q, prio_q;
  logic        mask_q, stat_q, fetch_q;
  logic        stat_clr;

  assign stat_clr = wr_en && (sel == SEL_STAT) && !wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      nxt_q   <= '0;
      ctrl_q  <= '0;
      prio_q  <= '0;
      mask_q  <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      fetch_q <= wr_en && (sel == SEL_CTRL) && wdata[CB_FETCH];
      if (wr_en) begin
        case (sel)
          SEL_CNT:  cnt_q  <= wdata;
          SEL_SRC:  src_q  <= wdata;
          SEL_DST:  dst_q  <= wdata;
          SEL_NXT:  nxt_q  <= wdata;
          SEL_CTRL: ctrl_q <= wdata & CTRL_WMASK;
          SEL_PRIO: prio_q <= wdata;
          SEL_MASK: mask_q <= wdata[0];
          default:  ;
        endcase
      end
    end
  end

  // completion flag: a completion event outranks a clearing write
  always_ff @(posedge clk) begin
    if (!rst_n)        stat_q <= 1'b0;
    else if (done_i)   stat_q <= 1'b1;
    else if (stat_clr) stat_q <= 1'b0;
  end

  always_comb begin
    case (sel)
      SEL_CNT:  rd_data_o = cnt_q;
      SEL_SRC:  rd_data_o = src_q;
      SEL_DST:  rd_data_o = dst_q;
      SEL_NXT:  rd_data_o = nxt_q;
      SEL_CTRL: rd_data_o = ctrl_q | (32'(busy_i) << CB_ACTIVE);
      SEL_PRIO: rd_data_o = prio_q;
      SEL_CUR:  rd_data_o = cur_desc_i;
      SEL_MASK: rd_data_o = {31'b0, mask_q};
      SEL_STAT: rd_data_o = {31'b0, stat_q};
      default:  rd_data_o = '0;
    endcase
  end

  assign cnt_o    = cnt_q;
  assign src_o    = src_q;
  assign dst_o    = dst_q;
  assign nxt_o    = nxt_q;
  assign enable_o = ctrl_q[CB_ENABLE];
  assign abort_o  = ctrl_q[CB_ABORT];
  assign chain_o  = ctrl_q[CB_CHAIN];
  assign burst_o  = ctrl_q[CB_BURST +: 3];
  assign sdir_o   = ctrl_q[CB_SDIR +: 2];
  assign ddir_o   = ctrl_q[CB_DDIR +: 2];
  assign sample_o = ctrl_q[CB_SAMPLE +: 3];
  assign fetch_o  = fetch_q;
  assign stat_o   = stat_q;
  assign mask_o   = mask_q;

  // R8: completion latches regardless of the enable
  p_done_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> stat_q);

  // R9: flag moves only on a completion or a write to its group
  p_stat_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && !(wr_en && sel == SEL_STAT)) |=> $stable(stat_q));
endmodule

// File: rtl/tdma_irq_merge.sv
module tdma_irq_merge #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] stat_i,
  input  logic [NCH-1:0] mask_i,
  output logic           irq_o
);
  logic [NCH-1:0] pend;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_pend
      assign pend[i] = stat_i[i] & mask_i[i];
    end
  endgenerate

  assign irq_o = |pend;
endmodule

// File: rtl/tdma_regbank.sv
module tdma_regbank
  import tdma_regs_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wen,
  input  logic                  bus_ren,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_rvalid,
  input  logic [NCH-1:0]        ch_busy,
  input  logic [NCH-1:0][31:0]  ch_cur_desc,
  input  logic [NCH-1:0]        ch_done,
  output logic [NCH-1:0][31:0]  ch_byte_cnt,
  output logic [NCH-1:0][31:0]  ch_src_addr,
  output logic [NCH-1:0][31:0]  ch_dst_addr,
  output logic [NCH-1:0][31:0]  ch_next_desc,
  output logic [NCH-1:0]        ch_enable,
  output logic [NCH-1:0]        ch_abort,
  output logic [NCH-1:0]        ch_chain,
  output logic [NCH-1:0]        ch_fetch,
  output logic [NCH-1:0][2:0]   ch_burst,
  output logic [NCH-1:0][1:0]   ch_src_dir,
  output logic [NCH-1:0][1:0]   ch_dst_dir,
  output logic [NCH-1:0][2:0]   ch_sample,
  output logic                  irq
);
  localparam int CH_W = 2;  // fixed by 4-byte stride inside 16-byte groups

  reg_sel_e        dec_sel;
  logic [CH_W-1:0] dec_chan;
  logic            dec_hit;
  logic [31:0]     rd_arr [NCH];
  logic [31:0]     rd_pick;
  logic [NCH-1:0]  stat_v, mask_v;

  tdma_addr_dec #(.ADDR_W(ADDR_W), .NCH(NCH), .CH_W(CH_W)) u_dec (
    .addr(bus_addr), .sel(dec_sel), .chan(dec_chan), .hit(dec_hit)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic wr_here;
      assign wr_here = bus_wen && dec_hit && (dec_chan == CH_W'(i));

      tdma_chan_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_here),
        .sel       (dec_sel),
        .wdata     (bus_wdata),
        .busy_i    (ch_busy[i]),
        .cur_desc_i(ch_cur_desc[i]),
        .done_i    (ch_done[i]),
        .rd_data_o (rd_arr[i]),
        .cnt_o     (ch_byte_cnt[i]),
        .src_o     (ch_src_addr[i]),
        .dst_o     (ch_dst_addr[i]),
        .nxt_o     (ch_next_desc[i]),
        .enable_o  (ch_enable[i]),
        .abort_o   (ch_abort[i]),
        .chain_o   (ch_chain[i]),
        .fetch_o   (ch_fetch[i]),
        .burst_o   (ch_burst[i]),
        .sdir_o    (ch_src_dir[i]),
        .ddir_o    (ch_dst_dir[i]),
        .sample_o  (ch_sample[i]),
        .stat_o    (stat_v[i]),
        .mask_o    (mask_v[i])
      );

      // R6: a fetch pulse always stems from a register write one cycle earlier
      p_fetch_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_fetch[i] |-> $past(bus_wen));
    end
  endgenerate

  always_comb begin
    rd_pick = '0;
    for (int i = 0; i < NCH; i++) begin
      if (dec_chan == CH_W'(i)) rd_pick = rd_arr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_ren;
      if (bus_ren) bus_rdata <= dec_hit ? rd_pick : 32'h0;
    end
  end

  tdma_irq_merge #(.NCH(NCH)) u_irq (
    .stat_i(stat_v), .mask_i(mask_v), .irq_o(irq)
  );

  // R3: read data follows the strobe by exactly one cycle
  p_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ren |=> bus_rvalid);

  // R3: unmapped offsets read as zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ren && !dec_hit) |=> (bus_rdata == 32'h0));

  // R10: the shared line only drops after a register write
  p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wen));
endmodule

// File: tb/tdma_regbank_tb.sv
module tdma_regbank_tb_top;
  localparam int NCH    = 2;
  localparam int ADDR_W = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 bus_wen = 1'b0;
  logic                 bus_ren = 1'b0;
  logic [ADDR_W-1:0]    bus_addr = '0;
  logic [31:0]          bus_wdata = '0;
  logic [31:0]          bus_rdata;
  logic                 bus_rvalid;
  logic [NCH-1:0]       ch_busy = '0;
  logic [NCH-1:0][31:0] ch_cur_desc = '0;
  logic [NCH-1:0]       ch_done = '0;
  logic [NCH-1:0][31:0] ch_byte_cnt, ch_src_addr, ch_dst_addr, ch_next_desc;
  logic [NCH-1:0]       ch_enable, ch_abort, ch_chain, ch_fetch;
  logic [NCH-1:0][2:0]  ch_burst, ch_sample;
  logic [NCH-1:0][1:0]  ch_src_dir, ch_dst_dir;
  logic                 irq;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic [31:0] e;
    string       t;
  } rd_item_t;
  rd_item_t exp_q[$];

  always #4 clk = ~clk;  // 125 MHz

  tdma_regbank #(.NCH(NCH), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .ch_busy(ch_busy), .ch_cur_desc(ch_cur_desc),
    .ch_done(ch_done), .ch_byte_cnt(ch_byte_cnt), .ch_src_addr(ch_src_addr),
    .ch_dst_addr(ch_dst_addr), .ch_next_desc(ch_next_desc),
    .ch_enable(ch_enable), .ch_abort(ch_abort), .ch_chain(ch_chain),
    .ch_fetch(ch_fetch), .ch_burst(ch_burst), .ch_src_dir(ch_src_dir),
    .ch_dst_dir(ch_dst_dir), .ch_sample(ch_sample), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  // driver: push the expected word, then issue the read
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    rd_item_t it;
    @(negedge clk);
    it.e = e; it.t = t;
    exp_q.push_back(it);
    bus_ren = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_ren = 1'b0;
  endtask

  task automatic done_pulse(input int c);
    @(negedge clk);
    ch_done[c] = 1'b1;
    @(negedge clk);
    ch_done[c] = 1'b0;
  endtask

  // monitor: compare each returned word against the scoreboard
  always @(posedge clk) begin
    rd_item_t got;
    #2;
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R3: actual=rvalid expected=no read pending");
      end else begin
        got = exp_q.pop_front();
        chk(got.t, bus_rdata, got.e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 irq", 32'(irq), 0);
    chk("R2 rvalid", 32'(bus_rvalid), 0);
    chk("R2 fetch", 32'(ch_fetch), 0);
    chk("R2 rdata", bus_rdata, 0);
    rst_n = 1'b1;
    rd(8'h00, 32'h0, "R2 len ch0");
    rd(8'h44, 32'h0, "R2 ctrl ch1");

    // R1 / R12 full-width storage and interleave
    wr(8'h00, 32'h0000_1000);
    wr(8'h04, 32'h0000_2000);
    wr(8'h10, 32'hA000_0000);
    wr(8'h24, 32'h5555_AAAA);
    wr(8'h30, 32'hDEAD_BEEF);
    wr(8'h64, 32'h0000_0005);
    rd(8'h00, 32'h0000_1000, "R1 len ch0");
    rd(8'h04, 32'h0000_2000, "R1 len ch1");
    rd(8'h10, 32'hA000_0000, "R12 src ch0");
    rd(8'h14, 32'h0, "R1 src ch1");
    rd(8'h24, 32'h5555_AAAA, "R12 dst ch1");
    rd(8'h33, 32'hDEAD_BEEF, "R1 next ch0 low bits ignored");
    rd(8'h64, 32'h5, "R12 prio ch1");
    chk("R12 len out ch1", ch_byte_cnt[1], 32'h2000);
    chk("R12 src out ch0", ch_src_addr[0], 32'hA000_0000);
    chk("R12 dst out ch1", ch_dst_addr[1], 32'h5555_AAAA);
    chk("R12 next out ch0", ch_next_desc[0], 32'hDEAD_BEEF);

    // R3 unmapped offsets
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h08, 32'h1234_5678);
    rd(8'h50, 32'h0, "R3 unlisted group");
    rd(8'h08, 32'h0, "R3 channel 2");
    rd(8'h00, 32'h0000_1000, "R3 write ignored ch0");
    rd(8'h04, 32'h0000_2000, "R3 write ignored ch1");

    // R4 / R6 control storage and fetch pulse
    wr(8'h40, 32'hFFFF_FFFF);
    chk("R6 fetch pulse ch0", 32'(ch_fetch[0]), 1);
    chk("R6 no fetch ch1", 32'(ch_fetch[1]), 0);
    @(negedge clk);
    chk("R6 fetch one cycle", 32'(ch_fetch[0]), 0);
    rd(8'h40, 32'h01F3_17FC, "R4 ctrl mask");

    // R5 active bit
    ch_busy[0] = 1'b1;
    rd(8'h40, 32'h01F3_57FC, "R5 active reads busy");
    ch_busy[0] = 1'b0;
    wr(8'h44, 32'h0000_4000);
    rd(8'h44, 32'h0, "R5 active write ignored");

    // R7 decoded fields
    wr(8'h44, 32'h0140_12E0);
    chk("R7 enable", 32'(ch_enable[1]), 1);
    chk("R7 burst", 32'(ch_burst[1]), 3);
    chk("R7 dst dir hold", 32'(ch_dst_dir[1]), 2);
    chk("R7 src dir inc", 32'(ch_src_dir[1]), 0);
    chk("R7 sample", 32'(ch_sample[1]), 5);
    chk("R7 chain", 32'(ch_chain[1]), 1);
    chk("R7 abort", 32'(ch_abort[1]), 0);
    chk("R7 ch0 abort", 32'(ch_abort[0]), 1);

    // R11 current descriptor
    ch_cur_desc[0] = 32'h1234_5670;
    ch_cur_desc[1] = 32'hCAFE_0010;
    wr(8'h70, 32'h0);
    rd(8'h70, 32'h1234_5670, "R11 cur ch0");
    rd(8'h74, 32'hCAFE_0010, "R11 cur ch1");

    // R8 / R9 / R10 completion and interrupt
    done_pulse(0);
    chk("R10 masked irq", 32'(irq), 0);
    rd(8'hA0, 32'h1, "R8 flag set while masked");
    wr(8'h80, 32'hFFFF_FFFF);
    chk("R10 irq on enable", 32'(irq), 1);
    rd(8'h80, 32'h1, "R10 enable bit only");
    wr(8'hA0, 32'hFFFF_FFFF);
    chk("R9 write one keeps irq", 32'(irq), 1);
    rd(8'hA0, 32'h1, "R9 write one keeps flag");
    wr(8'hA0, 32'hFFFF_FFFE);
    chk("R9 clear drops irq", 32'(irq), 0);
    rd(8'hA0, 32'h0, "R9 cleared");

    // R10 shared line across channels
    wr(8'h84, 32'h1);
    done_pulse(1);
    chk("R10 ch1 irq", 32'(irq), 1);
    done_pulse(0);
    wr(8'hA4, 32'h0);
    chk("R10 ch0 still holds irq", 32'(irq), 1);
    rd(8'hA4, 32'h0, "R10 ch1 cleared");
    wr(8'hA0, 32'h0);
    chk("R10 both clear", 32'(irq), 0);

    // R9 completion wins over simultaneous clear
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = 8'hA0; bus_wdata = 32'h0; ch_done[0] = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; ch_done[0] = 1'b0;
    chk("R9 done wins irq", 32'(irq), 1);
    rd(8'hA0, 32'h1, "R9 done wins flag");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R3: actual=%0d expected=0 reads outstanding", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule